// File: doc/BRIEF.md
# Dual-Modulus Pulse Swallow Frequency Divider

This block is the counter core of an integer-N frequency synthesizer. A fast feedback clock is divided by N×M+S. A dual-modulus prescaler divides by N or by N+1, and N is 64 or 128. Two counters steer it: a main counter that counts M prescaler periods and a swallow counter that counts S of those periods. A second, independent clock is divided by a binary value R to give the comparison reference. Each divider produces a one-clock-wide pulse at the end of every division cycle. A phase comparator outside the block consumes these two pulses.

The swallow controller is a three-state machine. SW_IDLE holds everything cleared. SW_SWALLOW runs the prescaler at N+1. SW_MAIN runs it at N. The transitions are:

- **start**: SW_IDLE goes to SW_SWALLOW, or to SW_MAIN when S is 0. It happens once the setting is valid and power-save is off.
- **swallow-done**: SW_SWALLOW goes to SW_MAIN on the prescaler period that brings the swallow count to S.
- **reload**: SW_MAIN goes back to SW_SWALLOW, or stays in SW_MAIN when the new S is 0. It happens on the prescaler period that brings the main count to M. The feedback pulse is emitted here and fresh values are captured.
- **abort**: any running state goes to SW_IDLE when the setting becomes invalid.

The reference divider has two states, RD_IDLE and RD_COUNT, with the same start, reload and abort rules. Power-save freezes both machines in place rather than resetting them.

Top module: `pulse_swallow_div`

## Requirements
- R1: With a valid setting, consecutive `fb_pulse` pulses are exactly N×M+S cycles of `vco_clk` apart. The first S prescaler periods of each cycle use N+1 and the remaining M−S periods use N.
- R2: `mod_sel` = 1 selects N = 64 (a 64/65 prescaler) and `mod_sel` = 0 selects N = 128 (a 128/129 prescaler).
- R3: `fb_pulse` is high for exactly one `vco_clk` cycle per division cycle.
- R4: With `ref_div` = R ≥ 1, consecutive `ref_pulse` pulses are exactly R cycles of `ref_clk` apart. For R ≥ 2 each pulse is one cycle wide.
- R5: A setting with M ≤ S (which includes M = 0) drives `cfg_invalid` high and keeps `fb_pulse` low. `ref_div` = 0 drives `cfg_invalid` high and keeps `ref_pulse` low. Restoring a valid setting restarts the affected divider.
- R6: While `pwr_save` is high, no pulse is produced and both dividers hold their counts. After release, the interrupted cycle resumes, so it is longer by exactly the number of clocks spent in power-save.
- R7: New M, S, `mod_sel` or R values take effect only at the next reload. The cycle in progress completes with the old values.
- R8: While `rst_n` is low, `fb_pulse` and `ref_pulse` are low.
- R9: S = 0 is legal and gives a ratio of exactly N×M, with no N+1 periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Feedback clock to be divided |
| ref_clk | input | 1 | Reference clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pwr_save | input | 1 | High freezes both dividers and silences the outputs |
| mod_sel | input | 1 | Prescaler choice: 1 selects 64/65, 0 selects 128/129 |
| main_div | input | 11 | Main count M, bit 0 is LSB |
| swallow_div | input | 7 | Swallow count S, bit 0 is LSB |
| ref_div | input | 14 | Reference division value R, bit 0 is LSB |
| fb_pulse | output | 1 | One-cycle pulse per N×M+S feedback clocks |
| ref_pulse | output | 1 | One-cycle pulse per R reference clocks |
| cfg_invalid | output | 1 | High when M ≤ S or R = 0 |

## Verification
The bench sweeps both prescaler sizes over every M from 1 to 4 and every S below M, and measures each pulse spacing against N×M+S. A design that misplaces the N+1 phase, or that counts S in the wrong state, is off by a few cycles or by a whole prescaler period in that sweep. A mid-cycle change of M and S must leave one old-length interval before the new one; a design that applies new values at once produces a shortened interval. The bench also checks a power-save window inside a cycle, which must stretch that interval by exactly its length. A divider that resets in power-save gives a full fresh cycle, and one that keeps counting gives the plain period. The bench drives the M = S, M = 0 and R = 0 settings and watches the outputs stay silent, then watches them restart cleanly.

// File: rtl/pss_pkg.sv
`timescale 1ns/1ps
package pss_pkg;
    typedef enum logic [1:0] {
        SW_IDLE    = 2'd0,
        SW_SWALLOW = 2'd1,
        SW_MAIN    = 2'd2
    } sw_state_t;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_COUNT = 1'b1
    } rd_state_t;
endpackage

// File: rtl/pss_prescaler.sv
`timescale 1ns/1ps
module pss_prescaler #(
    parameter int LOG_SMALL = 6,
    parameter int LOG_LARGE = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic small_sel,
    input  logic wide,
    output logic tick
);
    localparam int PW = LOG_LARGE + 1;
    localparam logic [PW-1:0] SMALL_TOP = PW'((1 << LOG_SMALL) - 1);
    localparam logic [PW-1:0] LARGE_TOP = PW'((1 << LOG_LARGE) - 1);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit = (small_sel ? SMALL_TOP : LARGE_TOP) + PW'(wide);
        tick  = en && !clr && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

    // R2: the count never passes the end of the selected modulus
    p_prescale_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (cnt_q <= limit));
endmodule

// File: rtl/pss_swallow_fsm.sv
`timescale 1ns/1ps
module pss_swallow_fsm
    import pss_pkg::*;
#(
    parameter int M_W       = 11,
    parameter int S_W       = 7,
    parameter int LOG_SMALL = 6,
    parameter int LOG_LARGE = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sleep,
    input  logic           cfg_ok,
    input  logic           sel_in,
    input  logic [M_W-1:0] m_in,
    input  logic [S_W-1:0] s_in,
    output logic           fb_pulse
);
    sw_state_t      state_q, state_d;
    logic [M_W-1:0] m_q, mcnt_q;
    logic [S_W-1:0] s_q, scnt_q;
    logic           sel_q;
    logic           tick;
    logic           last_m, last_s, reload, load_evt;
    sw_state_t      restart_st;

    pss_prescaler #(
        .LOG_SMALL (LOG_SMALL),
        .LOG_LARGE (LOG_LARGE)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (state_q == SW_IDLE),
        .en        (!sleep),
        .small_sel (sel_q),
        .wide      (state_q == SW_SWALLOW),
        .tick      (tick)
    );

    always_comb begin
        last_m     = (mcnt_q == m_q - 1'b1);
        last_s     = (scnt_q == s_q - 1'b1);
        reload     = (state_q == SW_MAIN) && tick && last_m;
        restart_st = (s_in != '0) ? SW_SWALLOW : SW_MAIN;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE: begin
                if (!sleep && cfg_ok) state_d = restart_st;          // start
            end
            SW_SWALLOW: begin
                if (!sleep) begin
                    if (!cfg_ok)              state_d = SW_IDLE;     // abort
                    else if (tick && last_s)  state_d = SW_MAIN;     // swallow-done
                end
            end
            SW_MAIN: begin
                if (!sleep) begin
                    if (!cfg_ok)     state_d = SW_IDLE;              // abort
                    else if (reload) state_d = restart_st;           // reload
                end
            end
            default: state_d = SW_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_IDLE;
        else        state_q <= state_d;
    end

    assign load_evt = (state_d != SW_IDLE) && ((state_q == SW_IDLE) || reload);

    // counters and captured setting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q    <= '0;
            s_q    <= '0;
            sel_q  <= 1'b0;
            mcnt_q <= '0;
            scnt_q <= '0;
        end else if (load_evt) begin
            m_q    <= m_in;
            s_q    <= s_in;
            sel_q  <= sel_in;
            mcnt_q <= '0;
            scnt_q <= '0;
        end else if (state_d == SW_IDLE) begin
            mcnt_q <= '0;
            scnt_q <= '0;
        end else if (tick) begin
            mcnt_q <= mcnt_q + 1'b1;
            if (state_q == SW_SWALLOW) scnt_q <= scnt_q + 1'b1;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fb_pulse <= 1'b0;
        else        fb_pulse <= reload && cfg_ok;
    end

    p_one_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);
    p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !fb_pulse);
    p_sleep_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(mcnt_q) && $stable(scnt_q) && $stable(state_q)));
    p_invalid_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |=> !fb_pulse);
    p_swallow_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_SWALLOW) |-> (scnt_q < s_q));
    p_main_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SW_IDLE) |-> (mcnt_q < m_q));
    p_held_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SW_IDLE) |-> (m_q > M_W'(s_q)));
endmodule

// File: rtl/pss_ref_div.sv
`timescale 1ns/1ps
module pss_ref_div
    import pss_pkg::*;
#(
    parameter int R_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sleep,
    input  logic [R_W-1:0] r_in,
    output logic           pulse
);
    rd_state_t      state_q, state_d;
    logic [R_W-1:0] r_q, cnt_q;
    logic           r_ok, wrap;

    always_comb begin
        r_ok = (r_in != '0);
        wrap = (state_q == RD_COUNT) && !sleep && (cnt_q == r_q - 1'b1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (!sleep && r_ok)  state_d = RD_COUNT;   // start
            RD_COUNT: if (!sleep && !r_ok) state_d = RD_IDLE;    // abort
            default:  state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q   <= '0;
            cnt_q <= '0;
        end else if ((state_q == RD_IDLE && state_d == RD_COUNT) || (wrap && r_ok)) begin
            r_q   <= r_in;
            cnt_q <= '0;
        end else if (state_d == RD_IDLE) begin
            cnt_q <= '0;
        end else if (state_q == RD_COUNT && !sleep) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= wrap && r_ok;
    end

    p_ref_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !pulse);
    p_ref_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_in == '0) |=> !pulse);
    p_ref_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_COUNT) |-> (cnt_q < r_q));
endmodule

// File: rtl/pulse_swallow_div.sv
`timescale 1ns/1ps
module pulse_swallow_div #(
    parameter int M_W       = 11,
    parameter int S_W       = 7,
    parameter int R_W       = 14,
    parameter int LOG_SMALL = 6,
    parameter int LOG_LARGE = 7
) (
    input  logic           vco_clk,
    input  logic           ref_clk,
    input  logic           rst_n,
    input  logic           pwr_save,
    input  logic           mod_sel,
    input  logic [M_W-1:0] main_div,
    input  logic [S_W-1:0] swallow_div,
    input  logic [R_W-1:0] ref_div,
    output logic           fb_pulse,
    output logic           ref_pulse,
    output logic           cfg_invalid
);
    logic fb_ok;

    assign fb_ok       = (main_div > M_W'(swallow_div));
    assign cfg_invalid = !fb_ok || (ref_div == '0);

    pss_swallow_fsm #(
        .M_W       (M_W),
        .S_W       (S_W),
        .LOG_SMALL (LOG_SMALL),
        .LOG_LARGE (LOG_LARGE)
    ) u_fb (
        .clk      (vco_clk),
        .rst_n    (rst_n),
        .sleep    (pwr_save),
        .cfg_ok   (fb_ok),
        .sel_in   (mod_sel),
        .m_in     (main_div),
        .s_in     (swallow_div),
        .fb_pulse (fb_pulse)
    );

    pss_ref_div #(
        .R_W (R_W)
    ) u_ref (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .sleep (pwr_save),
        .r_in  (ref_div),
        .pulse (ref_pulse)
    );

    // R8: both outputs stay silent while reset is applied
    always_comb begin
        if (!rst_n) begin
            a_reset_quiet_r8: assert (!fb_pulse && !ref_pulse);
        end
    end
endmodule

// File: tb/pulse_swallow_div_tb.sv
`timescale 1ns/1ps
module pulse_swallow_div_tb;
    logic        vco_clk = 1'b0;
    logic        ref_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        pwr_save = 1'b0;
    logic        mod_sel = 1'b1;
    logic [10:0] main_div = 11'd2;
    logic [6:0]  swallow_div = 7'd1;
    logic [13:0] ref_div = 14'd5;
    logic        fb_pulse, ref_pulse, cfg_invalid;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 vco_clk = ~vco_clk;
    initial begin
        #2;
        forever #4 ref_clk = ~ref_clk;
    end

    pulse_swallow_div u_dut (
        .vco_clk     (vco_clk),
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .pwr_save    (pwr_save),
        .mod_sel     (mod_sel),
        .main_div    (main_div),
        .swallow_div (swallow_div),
        .ref_div     (ref_div),
        .fb_pulse    (fb_pulse),
        .ref_pulse   (ref_pulse),
        .cfg_invalid (cfg_invalid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_fb(output int cycles);
        cycles = 0;
        do begin
            @(negedge vco_clk);
            cycles++;
        end while (!fb_pulse && cycles < 5000);
    endtask

    task automatic wait_ref(output int cycles);
        cycles = 0;
        do begin
            @(negedge ref_clk);
            cycles++;
        end while (!ref_pulse && cycles < 5000);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int iv, dummy, seen, exp;
        // R8: reset state
        repeat (5) @(negedge vco_clk);
        chk(!fb_pulse && !ref_pulse, "R8 reset outputs", {fb_pulse, ref_pulse}, 0);
        rst_n = 1'b1;

        // R1, R2, R9: sweep both prescalers over small M and S
        for (int sel = 0; sel < 2; sel++) begin
            for (int m = 1; m <= 4; m++) begin
                for (int s = 0; s < m; s++) begin
                    mod_sel     = sel[0];
                    main_div    = 11'(m);
                    swallow_div = 7'(s);
                    wait_fb(dummy);
                    wait_fb(iv);
                    exp = (sel == 1 ? 64 : 128) * m + s;
                    if (s == 0) chk(iv == exp, "R9 ratio N*M with S=0", iv, exp);
                    else        chk(iv == exp, "R1/R2 ratio N*M+S", iv, exp);
                end
            end
        end

        // R3: pulse is a single cycle wide
        wait_fb(dummy);
        @(negedge vco_clk);
        chk(!fb_pulse, "R3 pulse width", fb_pulse, 0);

        // R7: mid-cycle change applies only after the next reload
        mod_sel = 1'b1; main_div = 11'd3; swallow_div = 7'd1;
        wait_fb(dummy);
        wait_fb(dummy);
        repeat (50) @(negedge vco_clk);
        main_div = 11'd2; swallow_div = 7'd0;
        wait_fb(iv);
        chk(iv + 50 == 193, "R7 old cycle completes", iv + 50, 193);
        wait_fb(iv);
        chk(iv == 128, "R7 new value after reload", iv, 128);

        // R6: power-save window stretches the interrupted cycle
        main_div = 11'd3; swallow_div = 7'd1;
        wait_fb(dummy);
        wait_fb(dummy);
        repeat (20) @(negedge vco_clk);
        pwr_save = 1'b1;
        seen = 0;
        for (int k = 0; k < 37; k++) begin
            @(negedge vco_clk);
            if (fb_pulse || ref_pulse) seen++;
        end
        pwr_save = 1'b0;
        chk(seen == 0, "R6 no pulses in power-save", seen, 0);
        wait_fb(iv);
        chk(20 + 37 + iv == 230, "R6 cycle resumes after power-save", 20 + 37 + iv, 230);

        // R5: invalid feedback settings
        main_div = 11'd2; swallow_div = 7'd2;
        @(negedge vco_clk);
        chk(cfg_invalid, "R5 flag for M=S", cfg_invalid, 1);
        seen = 0;
        for (int k = 0; k < 600; k++) begin
            @(negedge vco_clk);
            if (fb_pulse) seen++;
        end
        chk(seen == 0, "R5 silent for M=S", seen, 0);
        main_div = 11'd0; swallow_div = 7'd0;
        @(negedge vco_clk);
        chk(cfg_invalid, "R5 flag for M=0", cfg_invalid, 1);
        seen = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge vco_clk);
            if (fb_pulse) seen++;
        end
        chk(seen == 0, "R5 silent for M=0", seen, 0);
        main_div = 11'd2; swallow_div = 7'd1; mod_sel = 1'b1;
        @(negedge vco_clk);
        chk(!cfg_invalid, "R5 flag clears", cfg_invalid, 0);
        wait_fb(dummy);
        wait_fb(iv);
        chk(iv == 129, "R5 restart after invalid", iv, 129);

        // R4: reference divider sweep
        for (int r = 2; r <= 9; r++) begin
            @(negedge ref_clk);
            ref_div = 14'(r);
            wait_ref(dummy);
            wait_ref(iv);
            chk(iv == r, "R4 reference interval", iv, r);
            @(negedge ref_clk);
            chk(!ref_pulse, "R4 reference pulse width", ref_pulse, 0);
        end

        // R5: reference value of zero
        @(negedge ref_clk);
        ref_div = 14'd0;
        #1;
        chk(cfg_invalid, "R5 flag for R=0", cfg_invalid, 1);
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge ref_clk);
            if (ref_pulse) seen++;
        end
        chk(seen == 0, "R5 silent for R=0", seen, 0);
        ref_div = 14'd6;
        wait_ref(dummy);
        wait_ref(iv);
        chk(iv == 6, "R5 reference restart", iv, 6);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule